// File: doc/BRIEF.md
# Misaligned Bus Transfer Splitter

This block sits between a load/store request port and a 64-bit external data bus. A request carries a byte address, an operand size of 1, 2, 4 or 8 bytes, a direction, a memory/I-O select, a lock flag and a compare-exchange flag. The block decides whether the request fits in one bus cycle under the bus alignment rules. These rules are not natural alignment: 2- and 4-byte operands only have to stay inside a 4-byte region, and 8-byte operands inside an 8-byte region. A request that crosses its region boundary is cut there into pieces. Each piece goes out as one bus cycle carrying a quadword address, active-high byte enables and write data on the proper lanes.

The order of the pieces depends on direction and address space. I/O writes send the high part first, and every other kind of access sends the low part first. For a locked split sequence the lock and split-cycle indicators stay high from the first piece to the last acknowledge, with no gap. A backoff input stalls the sequence and keeps its place. Read pieces are merged into one right-justified result, announced by a single done pulse. A compare-exchange runs a read phase and then a write phase over the quadword. When the quadword is misaligned, each phase works in 4-byte halves, lower address first.

The state machine has three states. ST_IDLE accepts a request (transition IDLE→ISSUE on req_valid). ST_ISSUE presents one piece at a time; on an acknowledged piece it either steps to the next piece (ISSUE→ISSUE) or, after the final one, moves on (ISSUE→DONE). Backoff keeps it in ST_ISSUE with the bus idle. ST_DONE raises done for one cycle and always returns to idle (DONE→IDLE).

Top module: `split_xfer_unit`

## Requirements
- R1: Size encoding on req_size is 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. A 2- or 4-byte request whose bytes all lie inside one 4-byte-aligned region runs as one bus cycle, even when it is not naturally aligned (e.g. 2 bytes at 0x01 give byte enables 8'h06).
- R2: An 8-byte request inside one 8-byte-aligned region runs as one cycle with byte enables 8'hFF. A 1-byte request never splits.
- R3: A request that crosses its region boundary (4 bytes for sizes 2 and 4, 8 bytes for size 8) runs as two cycles. The low piece holds region_size − (address mod region_size) bytes and the high piece holds the rest. Example: 4 bytes at 0x07 give a 1-byte piece (quadword 0x00, enables 8'h80) and a 3-byte piece (quadword 0x08, enables 8'h07).
- R4: For memory reads, memory writes and I/O reads (req_io=0 means memory), the low piece is issued first.
- R5: For I/O writes (req_io=1, req_write=1), the high piece is issued first and the low piece second.
- R6: On a locked request that splits, bus_lock and bus_split are both high on every cycle from the first piece through the final acknowledge, including stall cycles. A locked request that does not split drives bus_lock only. An unlocked request drives neither.
- R7: With backoff low, each follow-on piece is presented in the cycle right after the previous piece is acknowledged.
- R8: While backoff is high, bus_valid is low. The pending piece and the order of the remaining pieces are kept, and the sequence resumes with the next unissued piece once backoff falls.
- R9: bus_be bit i enables byte lane i (bus_wdata/bus_rdata bits 8i+7..8i). Operand byte k travels on lane (address + k) mod 8. bus_addr is the piece's byte address with its low three bits cleared.
- R10: done is high for exactly one cycle, in the cycle after the final piece's acknowledge, for reads and writes alike. For reads, rdata then holds the merged operand right-justified, with upper bytes zero.
- R11: With req_cx=1 the operand is 8 bytes whatever req_size is. A read phase runs first and then a write phase of req_wdata. Each phase, when the quadword is misaligned, covers the half at the address and then the half at address+4, and each half is split at its 4-byte boundary. The result is 8 cycles when address bits 1:0 are nonzero, 4 cycles when the address is 4 mod 8, and 2 unsplit cycles when it is quadword-aligned. If req_lock=1, every cycle is locked.
- R12: req_ready is high only in the idle state. A request is taken on a cycle with req_valid and req_ready both high, and req_ready is low until the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | AW | Byte address of the operand |
| req_size | input | 2 | Operand size code (0..3 = 1,2,4,8 bytes) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_lock | input | 1 | Locked access |
| req_cx | input | 1 | Compare-exchange quadword sequence |
| req_wdata | input | 64 | Right-justified write operand |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 64 | Right-justified read result, valid with done |
| backoff | input | 1 | Stall: suspend issuing pieces |
| bus_valid | output | 1 | Bus cycle presented |
| bus_ack | input | 1 | Bus cycle completed (counts only with bus_valid) |
| bus_addr | output | AW | Quadword address of the cycle |
| bus_be | output | 8 | Active-high byte enables |
| bus_write | output | 1 | Cycle direction |
| bus_io | output | 1 | Cycle address space |
| bus_wdata | output | 64 | Lane-aligned write data |
| bus_rdata | input | 64 | Lane-aligned read data |
| bus_lock | output | 1 | Lock indicator |
| bus_split | output | 1 | Split-cycle indicator |

## Verification
Two functions of this block can meet in one cycle: the automatic issue of a follow-on piece and a backoff stall. The bench raises backoff on the exact cycle in which the second piece of a locked split write would otherwise appear. This is the first cycle after the first acknowledge. Backoff is held for three cycles. The run is judged correct when bus_valid stays low and bus_lock stays high through the stall, the second piece appears exactly four cycles after the first with its own address and enables, and memory ends with the intended bytes, which a later read returns right-justified.

// File: rtl/split_pkg.sv
package split_pkg;
    localparam int LANES = 8;
    localparam int DW    = LANES * 8;
    localparam int MAXP  = 8;
    localparam int IW    = $clog2(MAXP);
    localparam int CW    = IW + 1;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DONE} state_t;

    typedef struct packed {
        logic [2:0] start;   // first operand byte of the piece
        logic [3:0] len;     // number of bytes in the piece
        logic       wr;      // piece direction
    } piece_t;

    function automatic piece_t mkp(input logic [3:0] s, input logic [3:0] l, input logic w);
        piece_t p;
        p.start = s[2:0];
        p.len   = l;
        p.wr    = w;
        return p;
    endfunction

    function automatic logic [DW-1:0] rotl_bytes(input logic [DW-1:0] d, input logic [2:0] sh);
        logic [2*DW-1:0] t;
        t = {d, d} << (8 * sh);
        return t[2*DW-1:DW];
    endfunction

    function automatic logic [DW-1:0] rotr_bytes(input logic [DW-1:0] d, input logic [2:0] sh);
        logic [2*DW-1:0] t;
        t = {d, d} >> (8 * sh);
        return t[DW-1:0];
    endfunction
endpackage

// File: rtl/split_plan.sv
module split_plan
    import split_pkg::*;
(
    input  logic                  [2:0]  addr_lo,
    input  logic                  [1:0]  size,
    input  logic                         write,
    input  logic                         io,
    input  logic                         cx,
    output piece_t [MAXP-1:0]            pcs,
    output logic                  [CW-1:0] cnt,
    output logic                         split
);
    always_comb begin : plan
        logic [3:0] n, off, rsz, lo_len;
        pcs    = '0;
        cnt    = CW'(1);
        split  = 1'b0;
        n      = 4'd1 << size;
        off    = 4'd0;
        rsz    = 4'd4;
        lo_len = 4'd0;
        if (cx) begin
            if (addr_lo == 3'd0) begin
                pcs[0] = mkp(4'd0, 4'd8, 1'b0);
                pcs[1] = mkp(4'd0, 4'd8, 1'b1);
                cnt    = CW'(2);
            end else begin
                split = 1'b1;
                off   = {2'b00, addr_lo[1:0]};
                if (off == 4'd0) begin
                    for (int ph = 0; ph < 2; ph++) begin
                        pcs[2*ph]   = mkp(4'd0, 4'd4, ph[0]);
                        pcs[2*ph+1] = mkp(4'd4, 4'd4, ph[0]);
                    end
                    cnt = CW'(4);
                end else begin
                    lo_len = 4'd4 - off;
                    for (int ph = 0; ph < 2; ph++) begin
                        pcs[4*ph]   = mkp(4'd0, lo_len, ph[0]);
                        pcs[4*ph+1] = mkp(lo_len, off, ph[0]);
                        pcs[4*ph+2] = mkp(4'd4, lo_len, ph[0]);
                        pcs[4*ph+3] = mkp(4'd4 + lo_len, off, ph[0]);
                    end
                    cnt = CW'(8);
                end
            end
        end else begin
            rsz = (size == 2'd3) ? 4'd8 : 4'd4;
            off = (size == 2'd3) ? {1'b0, addr_lo} : {2'b00, addr_lo[1:0]};
            if (off + n > rsz) begin
                split  = 1'b1;
                lo_len = rsz - off;
                cnt    = CW'(2);
                if (io && write) begin
                    pcs[0] = mkp(lo_len, n - lo_len, write);
                    pcs[1] = mkp(4'd0, lo_len, write);
                end else begin
                    pcs[0] = mkp(4'd0, lo_len, write);
                    pcs[1] = mkp(lo_len, n - lo_len, write);
                end
            end else begin
                pcs[0] = mkp(4'd0, n, write);
            end
        end
    end
endmodule

// File: rtl/split_lanes.sv
module split_lanes
    import split_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    base_addr,
    input  piece_t           pc,
    output logic [AW-1:0]    quad_addr,
    output logic [LANES-1:0] be
);
    logic [AW-1:0]        pa;
    logic [2*LANES-1:0]   span;
    logic [2*LANES-1:0]   placed;

    always_comb begin
        pa        = base_addr + AW'(pc.start);
        quad_addr = {pa[AW-1:3], 3'b000};
        span      = ((2*LANES)'(1) << pc.len) - (2*LANES)'(1);
        placed    = span << pa[2:0];
        be        = placed[LANES-1:0];
    end
endmodule

// File: rtl/split_merge.sv
module split_merge
    import split_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [LANES-1:0] be,
    input  logic [DW-1:0]    lane_data,
    input  logic [2:0]       addr_lo,
    input  logic [3:0]       nbytes,
    output logic [DW-1:0]    result
);
    logic [LANES-1:0][7:0] acc;
    logic [DW-1:0]         keep;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                acc[i] <= '0;
            else if (clr)              acc[i] <= '0;
            else if (take && be[i])    acc[i] <= lane_data[8*i +: 8];
        end
    end

    always_comb begin
        keep   = (nbytes >= 4'd8) ? '1 : ((DW'(1) << (8 * nbytes)) - DW'(1));
        result = rotr_bytes(acc, addr_lo) & keep;
    end
endmodule

// File: rtl/split_xfer_unit.sv
module split_xfer_unit
    import split_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_addr,
    input  logic [1:0]       req_size,
    input  logic             req_write,
    input  logic             req_io,
    input  logic             req_lock,
    input  logic             req_cx,
    input  logic [DW-1:0]    req_wdata,
    output logic             done,
    output logic [DW-1:0]    rdata,
    input  logic             backoff,
    output logic             bus_valid,
    input  logic             bus_ack,
    output logic [AW-1:0]    bus_addr,
    output logic [LANES-1:0] bus_be,
    output logic             bus_write,
    output logic             bus_io,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    output logic             bus_lock,
    output logic             bus_split
);
    state_t               state;
    logic [IW-1:0]        idx;
    logic [AW-1:0]        r_addr;
    logic [1:0]           r_size;
    logic                 r_write, r_io, r_lock, r_cx;
    logic [DW-1:0]        r_wd;

    piece_t [MAXP-1:0]    pcs;
    logic [CW-1:0]        cnt;
    logic                 is_split;
    piece_t               cur;
    logic                 fire, last, take_req;
    logic [3:0]           nbytes;

    split_plan u_plan (
        .addr_lo (r_addr[2:0]),
        .size    (r_size),
        .write   (r_write),
        .io      (r_io),
        .cx      (r_cx),
        .pcs     (pcs),
        .cnt     (cnt),
        .split   (is_split)
    );

    assign cur      = pcs[idx];
    assign fire     = bus_valid && bus_ack;
    assign last     = ({1'b0, idx} == (cnt - CW'(1)));
    assign take_req = req_valid && req_ready;
    assign nbytes   = r_cx ? 4'd8 : (4'd1 << r_size);

    split_lanes #(.AW(AW)) u_lanes (
        .base_addr (r_addr),
        .pc        (cur),
        .quad_addr (bus_addr),
        .be        (bus_be)
    );

    split_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (take_req),
        .take      (fire && !cur.wr),
        .be        (bus_be),
        .lane_data (bus_rdata),
        .addr_lo   (r_addr[2:0]),
        .nbytes    (nbytes),
        .result    (rdata)
    );

    // State register: request capture and piece sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            r_addr  <= '0;
            r_size  <= '0;
            r_write <= 1'b0;
            r_io    <= 1'b0;
            r_lock  <= 1'b0;
            r_cx    <= 1'b0;
            r_wd    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        r_addr  <= req_addr;
                        r_size  <= req_size;
                        r_write <= req_write;
                        r_io    <= req_io;
                        r_lock  <= req_lock;
                        r_cx    <= req_cx;
                        r_wd    <= rotl_bytes(req_wdata, req_addr[2:0]);
                        idx     <= '0;
                        state   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (fire) begin
                        if (last) state <= ST_DONE;
                        else      idx   <= idx + IW'(1);
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs per state
    always_comb begin
        req_ready = 1'b0;
        bus_valid = 1'b0;
        bus_lock  = 1'b0;
        bus_split = 1'b0;
        done      = 1'b0;
        bus_write = cur.wr;
        bus_io    = r_io;
        bus_wdata = r_wd;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: begin
                bus_valid = !backoff;
                bus_lock  = r_lock;
                bus_split = r_lock && is_split;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock && !(fire && last)) |=> bus_lock); // R6
    AST_SPLIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_split && !(fire && last)) |=> (bus_split && bus_lock)); // R6
    AST_PIECE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_be) && $stable(bus_write))); // R8
    AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE && backoff) |=> (state == ST_ISSUE && $stable(idx))); // R8
    AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_be != '0 && bus_addr[2:0] == 3'd0)); // R9
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && last) |=> done); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |=> !req_ready); // R12
endmodule

// File: tb/test_split_xfer_unit.sv
module test_split_xfer_unit;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0, req_io = 1'b0, req_lock = 1'b0, req_cx = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        done;
    logic [63:0] rdata;
    logic        backoff = 1'b0;
    logic        bus_valid;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_addr;
    logic [7:0]  bus_be;
    logic        bus_write, bus_io, bus_lock, bus_split;
    logic [63:0] bus_wdata;
    logic [63:0] bus_rdata = '0;

    split_xfer_unit #(.AW(AW)) i_split_xfer_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write), .req_io(req_io),
        .req_lock(req_lock), .req_cx(req_cx), .req_wdata(req_wdata), .done(done),
        .rdata(rdata), .backoff(backoff), .bus_valid(bus_valid), .bus_ack(bus_ack),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_write(bus_write), .bus_io(bus_io),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_lock(bus_lock), .bus_split(bus_split)
    );

    always #10 clk = ~clk;  // 50 MHz

    int checks = 0, fails = 0, cyc = 0;
    logic [7:0]  mem [64];
    logic [31:0] lg_addr [16];
    logic [7:0]  lg_be [16];
    logic        lg_wr [16], lg_lock [16], lg_split [16];
    int          lg_cyc [16];
    int          log_n = 0, bo_at = -1, bo_left = 0, bo_err = 0, done_cnt = 0;
    logic        done_seen = 1'b0, hold_lock = 1'b0;
    logic [63:0] got_rd = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // Bus responder, backoff driver and completion monitor
    always @(negedge clk) begin
        if (bo_left > 0 && log_n == bo_at) begin backoff = 1'b1; bo_left--; end
        else backoff = 1'b0;
        #2;
        if (bus_valid) begin
            if (log_n < 16) begin
                lg_addr[log_n] = bus_addr; lg_be[log_n] = bus_be; lg_wr[log_n] = bus_write;
                lg_lock[log_n] = bus_lock; lg_split[log_n] = bus_split; lg_cyc[log_n] = cyc;
            end
            for (int i = 0; i < 8; i++) begin
                if (bus_write && bus_be[i]) mem[{bus_addr[5:3], 3'(i)}] = bus_wdata[8*i +: 8];
                bus_rdata[8*i +: 8] = mem[{bus_addr[5:3], 3'(i)}];
            end
            log_n++;
            bus_ack = 1'b1;
        end else bus_ack = 1'b0;
        if (backoff && (bus_valid || (hold_lock && !bus_lock))) bo_err++;
        if (done) begin done_cnt++; done_seen = 1'b1; got_rd = rdata; end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_rd(input int a, input int n);
        logic [63:0] v = '0;
        for (int k = 0; k < n; k++) v[8*k +: 8] = mem[a + k];
        return v;
    endfunction

    task automatic run_req(input logic [31:0] a, input logic [1:0] sz, input logic w, input logic io,
                           input logic lk, input logic cx, input logic [63:0] wd);
        @(negedge clk);
        #4;
        log_n = 0; done_cnt = 0; done_seen = 1'b0; bo_err = 0;
        req_addr = a; req_size = sz; req_write = w; req_io = io; req_lock = lk; req_cx = cx;
        req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        #4;
        req_valid = 1'b0;
        chk(!req_ready, "R12 busy after accept", 64'(req_ready), 64'd0);
        for (int t = 0; t < 200; t++) begin
            if (done_seen) break;
            @(negedge clk);
            #4;
        end
        repeat (3) @(negedge clk);
        #4;
        chk(done_cnt == 1, "R10 single done pulse", 64'(done_cnt), 64'd1);
    endtask

    task automatic piece(input int i, input logic [31:0] a, input logic [7:0] be, input logic wr, input string tag);
        chk(lg_addr[i] == a && lg_be[i] == be && lg_wr[i] == wr,
            tag, {lg_addr[i], 23'd0, lg_wr[i], lg_be[i]}, {a, 23'd0, wr, be});
    endtask

    task automatic t_reset();
        chk(req_ready && !bus_valid && !done && !bus_lock && !bus_split,
            "R12 reset state", {59'd0, req_ready, bus_valid, done, bus_lock, bus_split}, 64'h10);
    endtask

    task automatic t_inside_region();
        logic [63:0] e;
        e = mem_rd(1, 2);
        run_req(32'h01, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        chk(log_n == 1, "R1 2B@01 one cycle", 64'(log_n), 64'd1);
        piece(0, 32'h00, 8'h06, 1'b0, "R1 2B@01 lanes");
        chk(got_rd == e, "R10 2B@01 data", got_rd, e);
        e = mem_rd(4, 4);
        run_req(32'h04, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        chk(log_n == 1, "R1 4B@04 one cycle", 64'(log_n), 64'd1);
        piece(0, 32'h00, 8'hF0, 1'b0, "R1 4B@04 lanes");
        chk(got_rd == e, "R10 4B@04 data", got_rd, e);
        e = mem_rd(7, 1);
        run_req(32'h07, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        chk(log_n == 1 && lg_be[0] == 8'h80, "R2 1B@07 unsplit", 64'(lg_be[0]), 64'h80);
        chk(got_rd == e, "R10 1B@07 data", got_rd, e);
    endtask

    task automatic t_quad_writes();
        run_req(32'h08, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0807060504030201);
        chk(log_n == 1, "R2 8B@08 one cycle", 64'(log_n), 64'd1);
        piece(0, 32'h08, 8'hFF, 1'b1, "R2 8B@08 lanes");
        chk(mem_rd(8, 8) == 64'h0807060504030201, "R9 8B@08 memory", mem_rd(8, 8), 64'h0807060504030201);
        run_req(32'h03, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 64'h1817161514131211);
        chk(log_n == 2, "R3 8B@03 two cycles", 64'(log_n), 64'd2);
        piece(0, 32'h00, 8'hF8, 1'b1, "R4 8B@03 low piece first");
        piece(1, 32'h08, 8'h07, 1'b1, "R3 8B@03 high piece");
        chk(mem_rd(3, 8) == 64'h1817161514131211, "R9 8B@03 memory", mem_rd(3, 8), 64'h1817161514131211);
    endtask

    task automatic t_split_read();
        logic [63:0] e;
        e = mem_rd(7, 4);
        run_req(32'h07, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        chk(log_n == 2, "R3 4B@07 two cycles", 64'(log_n), 64'd2);
        piece(0, 32'h00, 8'h80, 1'b0, "R4 4B@07 low piece first");
        piece(1, 32'h08, 8'h07, 1'b0, "R3 4B@07 high piece");
        chk(lg_cyc[1] == lg_cyc[0] + 1, "R7 back-to-back", 64'(lg_cyc[1] - lg_cyc[0]), 64'd1);
        chk(!lg_lock[0] && !lg_split[0] && !lg_lock[1] && !lg_split[1], "R6 unlocked no indicators",
            {lg_lock[0], lg_split[0], lg_lock[1], lg_split[1]}, 64'd0);
        chk(got_rd == e, "R10 4B@07 merged", got_rd, e);
    endtask

    task automatic t_io_order();
        run_req(32'h06, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 64'hCAFEF00D);
        chk(log_n == 2, "R5 io wr two cycles", 64'(log_n), 64'd2);
        piece(0, 32'h08, 8'h03, 1'b1, "R5 io wr high first");
        piece(1, 32'h00, 8'hC0, 1'b1, "R5 io wr low second");
        chk(mem_rd(6, 4) == 64'hCAFEF00D, "R9 io wr memory", mem_rd(6, 4), 64'hCAFEF00D);
        run_req(32'h06, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, '0);
        piece(0, 32'h00, 8'hC0, 1'b0, "R4 io rd low first");
        piece(1, 32'h08, 8'h03, 1'b0, "R4 io rd high second");
        chk(got_rd == 64'hCAFEF00D, "R10 io rd merged", got_rd, 64'hCAFEF00D);
        run_req(32'h03, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 64'hBEEF);
        piece(0, 32'h00, 8'h10, 1'b1, "R5 2B@03 io wr high first");
        piece(1, 32'h00, 8'h08, 1'b1, "R5 2B@03 io wr low second");
        chk(mem_rd(3, 2) == 64'hBEEF, "R9 2B@03 memory", mem_rd(3, 2), 64'hBEEF);
    endtask

    task automatic t_locked_backoff();
        hold_lock = 1'b1; bo_at = 1; bo_left = 3;
        run_req(32'h07, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 64'hA1B2C3D4);
        hold_lock = 1'b0; bo_at = -1;
        chk(log_n == 2, "R8 pieces after stall", 64'(log_n), 64'd2);
        piece(0, 32'h00, 8'h80, 1'b1, "R8 first piece");
        piece(1, 32'h08, 8'h07, 1'b1, "R8 resumed piece");
        chk(lg_cyc[1] == lg_cyc[0] + 4, "R8 stall length", 64'(lg_cyc[1] - lg_cyc[0]), 64'd4);
        chk(bo_err == 0, "R8 quiet bus and R6 lock in stall", 64'(bo_err), 64'd0);
        chk(lg_lock[0] && lg_split[0] && lg_lock[1] && lg_split[1], "R6 locked split indicators",
            {lg_lock[0], lg_split[0], lg_lock[1], lg_split[1]}, 64'hF);
        run_req(32'h07, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        chk(got_rd == 64'hA1B2C3D4, "R9 locked write readback", got_rd, 64'hA1B2C3D4);
    endtask

    task automatic t_cx_split();
        logic [63:0] e;
        logic [31:0] qa [4];
        logic [7:0]  qb [4];
        qa = '{32'h00, 32'h08, 32'h08, 32'h08};
        qb = '{8'hE0, 8'h01, 8'h0E, 8'h10};
        e = mem_rd(5, 8);
        run_req(32'h05, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h1122334455667788);
        chk(log_n == 8, "R11 cx@05 eight cycles", 64'(log_n), 64'd8);
        for (int i = 0; i < 8; i++) begin
            piece(i, qa[i % 4], qb[i % 4], (i >= 4), "R11 cx@05 piece order");
            chk(lg_lock[i] && lg_split[i], "R11 cx@05 locked split", {lg_lock[i], lg_split[i]}, 64'h3);
        end
        chk(got_rd == e, "R11 cx@05 old value", got_rd, e);
        chk(mem_rd(5, 8) == 64'h1122334455667788, "R11 cx@05 new value", mem_rd(5, 8), 64'h1122334455667788);
    endtask

    task automatic t_cx_other();
        run_req(32'h14, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0F0E0D0C0B0A0908);
        chk(log_n == 4, "R11 cx@14 four cycles", 64'(log_n), 64'd4);
        piece(0, 32'h10, 8'hF0, 1'b0, "R11 cx@14 rd half0");
        piece(1, 32'h18, 8'h0F, 1'b0, "R11 cx@14 rd half1");
        piece(2, 32'h10, 8'hF0, 1'b1, "R11 cx@14 wr half0");
        piece(3, 32'h18, 8'h0F, 1'b1, "R11 cx@14 wr half1");
        run_req(32'h20, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h5A5A5A5A5A5A5A5A);
        chk(log_n == 2, "R11 cx@20 two cycles", 64'(log_n), 64'd2);
        piece(0, 32'h20, 8'hFF, 1'b0, "R11 cx@20 read");
        piece(1, 32'h20, 8'hFF, 1'b1, "R11 cx@20 write");
        chk(lg_lock[0] && lg_lock[1] && !lg_split[0] && !lg_split[1], "R6 locked unsplit lock only",
            {lg_lock[0], lg_split[0], lg_lock[1], lg_split[1]}, 64'hA);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(8'h40 + i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #4;
        t_reset();
        t_inside_region();
        t_split_read();
        t_quad_writes();
        t_io_order();
        t_locked_backoff();
        t_cx_split();
        t_cx_other();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule